// File: doc/BRIEF.md
# Logarithmic Pulse-Width Time-to-Digital Converter

This block turns the duration of a single digital pulse into a code that grows with the logarithm of that duration. The pulse comes from a sensing node that is precharged and then left to discharge by leakage; its width rises exponentially as temperature falls, so a logarithmic code tracks temperature roughly linearly. One counter does both jobs. It measures the time, and it also linearizes the result, because its counting rate halves at fixed steps as the pulse lasts longer.

A slow external trigger starts each conversion, at a few conversions per second. The pulse is first synchronized into the reference clock domain. Counting begins on a synchronized rising edge and ends when the pulse falls or the code reaches full scale. A ratio mode measures two successive pulses and reports the difference of their logarithmic codes. That difference stands for the ratio of the two widths and cancels factors that scale both widths alike.

Top module: `logtdc`

## Requirements
- R1: After reset, `resultCode` is 0, `doneFlag` is 0 and `overflowFlag` is 0.
- R2: `startReq` is accepted only while no conversion is in progress. A request that arrives during a conversion has no effect: it neither restarts the conversion nor changes the mode.
- R3: The pulse passes through a two-flop synchronizer. Counting begins only on a low-to-high transition of the synchronized pulse that is seen after the start was accepted. A pulse that is already high at start is ignored until it has gone low and risen again.
- R4: The code starts at 0, and the first synchronized high cycle is not counted. After that, each high cycle advances a prescaler. The code increments when the prescaler has run for the current terminal count. That terminal count is BASE_DIV cycles for codes 0 to 2^SEG_LOG-1, and it doubles for every further group of 2^SEG_LOG codes. With the defaults (CODE_W=6, SEG_LOG=3, BASE_DIV=1), a pulse 20 clocks wide gives code 13.
- R5: In single mode, the falling edge of the pulse ends the conversion. `resultCode` then holds the code zero-extended to CODE_W+1 bits, and `doneFlag` rises and stays high with the result held until the next accepted start.
- R6: If the code reaches full scale (2^CODE_W-1, 63 by default), the measurement ends at once. The code stays at full scale and `overflowFlag` is set with the result.
- R7: In ratio mode, two pulses are measured in turn. `resultCode` is the first code minus the second code, as a CODE_W+1-bit two's-complement number. `doneFlag` stays low between the two pulses.
- R8: In ratio mode, `overflowFlag` is set if either of the two measurements reached full scale.
- R9: An accepted start clears `doneFlag` at the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock that sets the count rate |
| rstN | input | 1 | Active-low synchronous reset |
| startReq | input | 1 | One-cycle request to begin a conversion |
| ratioSel | input | 1 | Selects two-pulse ratio mode; sampled when a start is accepted |
| pulseIn | input | 1 | Asynchronous pulse whose width is measured |
| resultCode | output | CODE_W+1 | Result: zero-extended code, or signed difference in ratio mode |
| overflowFlag | output | 1 | A measurement saturated at full scale |
| doneFlag | output | 1 | Result valid; held until the next accepted start |

## Verification
The assertions assume that `startReq` is a single-cycle strobe and that each pulse stays high and low for at least two reference cycles, so the synchronizer never merges or drops an edge. They also assume that `ratioSel` is stable in the cycle a start is taken. The bench drives every input on the falling clock edge and spaces its pulses by several cycles. It holds each pulse for an exact number of clocks, so the expected code follows from the width by walking the terminal-count schedule cycle by cycle.

// File: rtl/logtdc_pkg.sv
package logtdc_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ARM1,
    ST_CNT1,
    ST_ARM2,
    ST_CNT2
  } ctrlState_e;

  // strobes from the sequencer to the counting datapath
  typedef struct packed {
    logic clr;       // zero code and prescaler
    logic cnt;       // advance prescaler this cycle
    logic capFirst;  // store first code of a ratio pair
    logic finish;    // form the result word
    logic useRatio;  // result is a difference
  } dpStrobe_t;

endpackage

// File: rtl/logtdc_sync.sv
module logtdc_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic pulseIn,
  output logic syncLvl,
  output logic riseEdge
);

  logic [STAGES-1:0] chain;
  logic prevLvl;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk) begin
        if (!rstN) chain <= '0;
        else       chain <= pulseIn;
      end
    end else begin : g_multi
      always_ff @(posedge clk) begin
        if (!rstN) chain <= '0;
        else       chain <= {chain[STAGES-2:0], pulseIn};
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN) prevLvl <= 1'b0;
    else       prevLvl <= syncLvl;
  end

  assign syncLvl  = chain[STAGES-1];
  assign riseEdge = syncLvl & ~prevLvl;

  AST_RISE_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    riseEdge |=> !riseEdge); // R3

endmodule

// File: rtl/logtdc_ctrl.sv
module logtdc_ctrl
  import logtdc_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      startReq,
  input  logic      ratioSel,
  input  logic      syncLvl,
  input  logic      riseEdge,
  input  logic      atMax,
  output dpStrobe_t strobe,
  output logic      doneFlag
);

  ctrlState_e state, nextState;
  logic ratioQ;
  logic startTake;
  logic doneSet;
  logic measEnd;

  assign measEnd = atMax | ~syncLvl;

  always_comb begin
    nextState       = state;
    strobe          = '0;
    strobe.useRatio = ratioQ;
    startTake       = 1'b0;
    doneSet         = 1'b0;
    case (state)
      ST_IDLE: begin
        if (startReq) begin
          nextState  = ST_ARM1;
          strobe.clr = 1'b1;
          startTake  = 1'b1;
        end
      end
      ST_ARM1: begin
        if (riseEdge) begin
          nextState  = ST_CNT1;
          strobe.clr = 1'b1;
        end
      end
      ST_CNT1: begin
        if (measEnd) begin
          if (ratioQ) begin
            strobe.capFirst = 1'b1;
            nextState       = ST_ARM2;
          end else begin
            strobe.finish = 1'b1;
            doneSet       = 1'b1;
            nextState     = ST_IDLE;
          end
        end else begin
          strobe.cnt = 1'b1;
        end
      end
      ST_ARM2: begin
        if (riseEdge) begin
          nextState  = ST_CNT2;
          strobe.clr = 1'b1;
        end
      end
      ST_CNT2: begin
        if (measEnd) begin
          strobe.finish = 1'b1;
          doneSet       = 1'b1;
          nextState     = ST_IDLE;
        end else begin
          strobe.cnt = 1'b1;
        end
      end
      default: nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      ratioQ   <= 1'b0;
      doneFlag <= 1'b0;
    end else begin
      state <= nextState;
      if (startTake) ratioQ <= ratioSel;
      if (startTake)    doneFlag <= 1'b0;
      else if (doneSet) doneFlag <= 1'b1;
    end
  end

  AST_DONE_IN_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    doneFlag |-> state == ST_IDLE); // R5
  AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rstN)
    (state != ST_IDLE && startReq) |=> ratioQ == $past(ratioQ)); // R2
  AST_RATIO_NO_DONE: assert property (@(posedge clk) disable iff (!rstN)
    state == ST_ARM2 |-> !doneFlag); // R7
  AST_DONE_CLEARED: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE && startReq) |=> !doneFlag); // R9

endmodule

// File: rtl/logtdc_datapath.sv
module logtdc_datapath
  import logtdc_pkg::*;
#(
  parameter int CODE_W   = 6,
  parameter int SEG_LOG  = 3,
  parameter int BASE_DIV = 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strobe,
  output logic              atMax,
  output logic [CODE_W:0]   resultCode,
  output logic              overflowFlag
);

  localparam int SEG_W = CODE_W - SEG_LOG;
  localparam int PRE_W = $clog2(BASE_DIV) + (1 << SEG_W);
  localparam logic [CODE_W-1:0] MAX_CODE = {CODE_W{1'b1}};

  logic [CODE_W-1:0] code;
  logic [CODE_W-1:0] firstCode;
  logic              firstOvf;
  logic [PRE_W-1:0]  pre;
  logic [PRE_W-1:0]  tcMinus1;
  logic [SEG_W-1:0]  segIdx;
  logic              preWrap;

  assign segIdx   = code[CODE_W-1:SEG_LOG];
  assign tcMinus1 = (PRE_W'(BASE_DIV) << segIdx) - PRE_W'(1);
  assign preWrap  = (pre == tcMinus1);
  assign atMax    = (code == MAX_CODE);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      code <= '0;
      pre  <= '0;
    end else if (strobe.clr) begin
      code <= '0;
      pre  <= '0;
    end else if (strobe.cnt) begin
      if (preWrap) begin
        code <= code + 1'b1;
        pre  <= '0;
      end else begin
        pre <= pre + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      firstCode    <= '0;
      firstOvf     <= 1'b0;
      resultCode   <= '0;
      overflowFlag <= 1'b0;
    end else begin
      if (strobe.capFirst) begin
        firstCode <= code;
        firstOvf  <= atMax;
      end
      if (strobe.finish) begin
        if (strobe.useRatio) begin
          resultCode   <= {1'b0, firstCode} - {1'b0, code};
          overflowFlag <= atMax | firstOvf;
        end else begin
          resultCode   <= {1'b0, code};
          overflowFlag <= atMax;
        end
      end
    end
  end

  AST_CODE_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.cnt && !strobe.clr && preWrap) |=> code == CODE_W'($past(code) + 1'b1)); // R4
  AST_NO_WRAP: assert property (@(posedge clk) disable iff (!rstN)
    (atMax && !strobe.clr) |=> atMax); // R6
  AST_OVF_FULL: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.finish && !strobe.useRatio && atMax) |=> (overflowFlag && resultCode == {1'b0, MAX_CODE})); // R6

endmodule

// File: rtl/logtdc.sv
module logtdc
  import logtdc_pkg::*;
#(
  parameter int CODE_W   = 6,
  parameter int SEG_LOG  = 3,
  parameter int BASE_DIV = 1
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            startReq,
  input  logic            ratioSel,
  input  logic            pulseIn,
  output logic [CODE_W:0] resultCode,
  output logic            overflowFlag,
  output logic            doneFlag
);

  logic      syncLvl;
  logic      riseEdge;
  logic      atMax;
  dpStrobe_t strobe;

  logtdc_sync #(.STAGES(2)) u_sync (
    .clk      (clk),
    .rstN     (rstN),
    .pulseIn  (pulseIn),
    .syncLvl  (syncLvl),
    .riseEdge (riseEdge)
  );

  logtdc_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .startReq (startReq),
    .ratioSel (ratioSel),
    .syncLvl  (syncLvl),
    .riseEdge (riseEdge),
    .atMax    (atMax),
    .strobe   (strobe),
    .doneFlag (doneFlag)
  );

  logtdc_datapath #(
    .CODE_W   (CODE_W),
    .SEG_LOG  (SEG_LOG),
    .BASE_DIV (BASE_DIV)
  ) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .strobe       (strobe),
    .atMax        (atMax),
    .resultCode   (resultCode),
    .overflowFlag (overflowFlag)
  );

endmodule

// File: tb/logtdc_test.sv
module logtdc_test;

  localparam int CODE_W   = 6;
  localparam int SEG_LOG  = 3;
  localparam int BASE_DIV = 1;
  localparam int MAXC     = (1 << CODE_W) - 1;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic startReq = 1'b0;
  logic ratioSel = 1'b0;
  logic pulseIn = 1'b0;
  logic [CODE_W:0] resultCode;
  logic overflowFlag;
  logic doneFlag;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #10 clk = ~clk;

  logtdc #(.CODE_W(CODE_W), .SEG_LOG(SEG_LOG), .BASE_DIV(BASE_DIV)) uut (
    .clk(clk), .rstN(rstN), .startReq(startReq), .ratioSel(ratioSel),
    .pulseIn(pulseIn), .resultCode(resultCode),
    .overflowFlag(overflowFlag), .doneFlag(doneFlag)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000) begin
      errors = errors + 1;
      $display("FAIL watchdog: actual=%0d cycles expected=completion", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks + 1, errors);
      $finish;
    end
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // expected code for a pulse that is high for w clocks (R4, R6)
  function automatic int modelCode(input int w, output int ovf);
    int code = 0;
    int pre = 0;
    for (int i = 0; i < w - 1; i++) begin
      if (code == MAXC) break;
      if (pre == (BASE_DIV << (code >> SEG_LOG)) - 1) begin
        code++;
        pre = 0;
      end else begin
        pre++;
      end
    end
    ovf = (code == MAXC) ? 1 : 0;
    return code;
  endfunction

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic startConv(input logic ratio);
    @(negedge clk);
    startReq = 1'b1;
    ratioSel = ratio;
    @(negedge clk);
    startReq = 1'b0;
    ratioSel = 1'b0;
    idle(2);
  endtask

  task automatic pulse(input int w);
    @(negedge clk);
    pulseIn = 1'b1;
    repeat (w) @(negedge clk);
    pulseIn = 1'b0;
    idle(4);
  endtask

  task automatic waitDone(input string req);
    for (int i = 0; i < 5000; i++) begin
      if (doneFlag) break;
      @(negedge clk);
    end
    check(req, int'(doneFlag), 1);
  endtask

  task automatic t_reset();
    check("R1 result", int'(resultCode), 0);
    check("R1 done", int'(doneFlag), 0);
    check("R1 overflow", int'(overflowFlag), 0);
  endtask

  task automatic t_single(input int w);
    int ovf;
    int exp = modelCode(w, ovf);
    startConv(1'b0);
    pulse(w);
    waitDone("R5 done");
    check("R4 code", int'(resultCode), exp);
    check("R6 overflow", int'(overflowFlag), ovf);
    idle(10);
    check("R5 done held", int'(doneFlag), 1);
    check("R5 result held", int'(resultCode), exp);
  endtask

  task automatic t_preHigh();
    int ovf;
    int exp = modelCode(30, ovf);
    @(negedge clk);
    pulseIn = 1'b1;
    idle(5);
    startConv(1'b0);
    idle(10);
    pulseIn = 1'b0;
    idle(6);
    check("R3 no done from stale high", int'(doneFlag), 0);
    pulse(30);
    waitDone("R3 done");
    check("R3 code from fresh edge", int'(resultCode), exp);
  endtask

  task automatic t_busyStart();
    int ovf;
    int exp = modelCode(200, ovf);
    startConv(1'b0);
    @(negedge clk);
    pulseIn = 1'b1;
    idle(50);
    startReq = 1'b1;
    ratioSel = 1'b1;
    @(negedge clk);
    startReq = 1'b0;
    ratioSel = 1'b0;
    repeat (149) @(negedge clk);
    pulseIn = 1'b0;
    idle(4);
    waitDone("R2 done without second pulse");
    check("R2 result single", int'(resultCode), exp);
  endtask

  task automatic t_ratio(input int w1, input int w2);
    int o1, o2;
    int c1 = modelCode(w1, o1);
    int c2 = modelCode(w2, o2);
    startConv(1'b1);
    pulse(w1);
    idle(10);
    check("R7 done low between pulses", int'(doneFlag), 0);
    pulse(w2);
    waitDone("R7 done");
    check("R7 difference", int'($signed(resultCode)), c1 - c2);
    check("R8 overflow", int'(overflowFlag), (o1 | o2));
  endtask

  task automatic t_doneClear();
    startConv(1'b0);
    check("R9 done cleared", int'(doneFlag), 0);
    pulse(8);
    waitDone("R9 done again");
    check("R9 code", int'(resultCode), 7);
  endtask

  initial begin
    idle(3);
    t_reset();
    rstN = 1'b1;
    idle(3);
    t_single(1);
    t_single(5);
    t_single(20);
    t_single(100);
    t_single(3000);
    t_preHigh();
    t_busyStart();
    t_ratio(100, 20);
    t_ratio(10, 60);
    t_ratio(3000, 5);
    t_doneClear();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule